// File: doc/BRIEF.md
# Event Counter Status Register Bank

This block holds one status word for each up/down event counter in a performance-monitoring unit. Every word carries three live bits, two sticky flags and a semaphore bit. The live bits hold last cycle's increment hit, decrement hit and counting-enabled state. One sticky flag records a counter wrap and the other an illegal event-selection code. The semaphore is taken by reading it and given back by writing a one.

Software reaches the words through a plain register port with an address, a read strobe and a write strobe. The read data is combinational from the stored state while the read strobe is high. The side effect of a read, setting the semaphore, lands at the clock edge that ends the access. The per-counter event lines come from the counter logic as bit vectors, one bit per counter. The flag-clear line drops both sticky flags of its counter.

Top module: `evt_stat_bank`

## Requirements
- R1: Status word k sits at byte address 0x08 + 0x10*k, for k = 0 to 7. Every other address reads as 0, and a write to it changes no word.
- R2: Bit 31 of word k equals inc/dec input `dec_evt[k]` as sampled at the previous rising edge. It follows the input whether or not the counter is enabled.
- R3: Bit 30 of word k equals `inc_evt[k]` from the previous rising edge, whether or not the counter is enabled.
- R4: Bit 29 of word k equals `cnt_live[k]` from the previous rising edge.
- R5: Bit 28 is a semaphore. A read returns its present value, and after that read the bit is 1. The first read after reset returns 0.
- R6: Writing a 1 to bit 28 of word k makes the bit 0, and writing 0 there leaves it alone. A write of 1 in the same cycle as a read of that word wins, so the next read returns 0.
- R7: Bit 27 of word k is set one cycle after a pulse on `badsel_p[k]` and stays set until `flag_clr[k]`. A pulse together with the clear leaves the bit set.
- R8: Bit 26 of word k is set one cycle after a pulse on `roll_p[k]` and stays set until `flag_clr[k]`. A pulse together with the clear leaves the bit set.
- R9: Bits 25 to 0 of every word always read as 0.
- R10: After reset every bit of every word is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| addr | input | 8 | Byte address of the access |
| wdata | input | 32 | Write data (only bit 28 is used) |
| rdata | output | 32 | Read data, 0 when no word is read |
| inc_evt | input | 8 | Increment event seen, one bit per counter |
| dec_evt | input | 8 | Decrement event seen, one bit per counter |
| cnt_live | input | 8 | Counter enabled to count, one bit per counter |
| roll_p | input | 8 | Counter wrapped over or under, pulse per counter |
| badsel_p | input | 8 | Illegal event code written, pulse per counter |
| flag_clr | input | 8 | Clear both sticky flags, per counter |

## Verification
Some rules are checked every cycle by the assertions. These cover the one-cycle lag of the live bits behind their inputs. They cover semaphore set on read and clear on a write of one, and that the semaphore holds when its word is idle. They also cover sticky-flag set and clear priority, the zero reserved field, and zero data for unmapped reads. The bench scenarios show the rest: the value a read actually returns, which is the state before the read's own side effect. They also show the complete address map, including near-miss addresses, and that unmapped writes do not reach a real word. Finally they show the whole word returned under several mixed patterns of event bits.

// File: rtl/evs_pkg.sv
package evs_pkg;

   localparam int WORD_W   = 32;
   localparam int DEC_BIT  = 31;
   localparam int INC_BIT  = 30;
   localparam int LIVE_BIT = 29;
   localparam int SEM_BIT  = 28;
   localparam int BAD_BIT  = 27;
   localparam int ROLL_BIT = 26;

   typedef struct packed {
      logic dec;
      logic inc;
      logic live;
      logic sem;
      logic bad;
      logic roll;
   } slot_stat_t;

   function automatic logic [WORD_W-1:0] stat_word(slot_stat_t s);
      logic [WORD_W-1:0] w;
      w           = '0;
      w[DEC_BIT]  = s.dec;
      w[INC_BIT]  = s.inc;
      w[LIVE_BIT] = s.live;
      w[SEM_BIT]  = s.sem;
      w[BAD_BIT]  = s.bad;
      w[ROLL_BIT] = s.roll;
      return w;
   endfunction

endpackage

// File: rtl/evs_addr_dec.sv
module evs_addr_dec #(
   parameter int NUM_CTR  = 8,
   parameter int ADDR_W   = 8,
   parameter int BASE_OFS = 8,
   parameter int STRIDE   = 16
) (
   input  logic [ADDR_W-1:0]  addr,
   output logic [NUM_CTR-1:0] sel
);

   for (genvar k = 0; k < NUM_CTR; k++) begin : g_hit
      localparam logic [ADDR_W-1:0] SLOT_ADR = ADDR_W'(BASE_OFS + STRIDE * k);
      assign sel[k] = (addr == SLOT_ADR);
   end

endmodule

// File: rtl/evs_slot.sv
module evs_slot
   import evs_pkg::*;
#(
   parameter bit LIVE_REG = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       inc_evt,
   input  logic       dec_evt,
   input  logic       cnt_live,
   input  logic       roll_p,
   input  logic       badsel_p,
   input  logic       flag_clr,
   input  logic       rd_hit,
   input  logic       rel_hit,
   output slot_stat_t stat
);

   logic [2:0] live_q;
   logic       sem_q;
   logic       bad_q;
   logic       roll_q;

   if (LIVE_REG) begin : g_live_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) live_q <= '0;
         else        live_q <= {dec_evt, inc_evt, cnt_live};
      end
   end else begin : g_live_comb
      assign live_q = {dec_evt, inc_evt, cnt_live};
   end

   // release beats a concurrent read
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       sem_q <= 1'b0;
      else if (rel_hit) sem_q <= 1'b0;
      else if (rd_hit)  sem_q <= 1'b1;
   end

   // set beats clear for both sticky flags
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bad_q  <= 1'b0;
         roll_q <= 1'b0;
      end else begin
         if (badsel_p)      bad_q <= 1'b1;
         else if (flag_clr) bad_q <= 1'b0;
         if (roll_p)        roll_q <= 1'b1;
         else if (flag_clr) roll_q <= 1'b0;
      end
   end

   assign stat.dec  = live_q[2];
   assign stat.inc  = live_q[1];
   assign stat.live = live_q[0];
   assign stat.sem  = sem_q;
   assign stat.bad  = bad_q;
   assign stat.roll = roll_q;

endmodule

// File: rtl/evs_rd_mux.sv
module evs_rd_mux
   import evs_pkg::*;
#(
   parameter int NUM_CTR = 8
) (
   input  logic                      rd_en,
   input  logic [NUM_CTR-1:0]        sel,
   input  slot_stat_t [NUM_CTR-1:0]  stat_v,
   output logic [WORD_W-1:0]         rdata
);

   always_comb begin
      rdata = '0;
      for (int k = 0; k < NUM_CTR; k++) begin
         if (rd_en && sel[k]) rdata = rdata | stat_word(stat_v[k]);
      end
   end

endmodule

// File: rtl/evt_stat_bank.sv
module evt_stat_bank
   import evs_pkg::*;
#(
   parameter int NUM_CTR  = 8,
   parameter int ADDR_W   = 8,
   parameter int BASE_OFS = 8,
   parameter int STRIDE   = 16,
   parameter bit LIVE_REG = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               rd_en,
   input  logic               wr_en,
   input  logic [ADDR_W-1:0]  addr,
   input  logic [WORD_W-1:0]  wdata,
   output logic [WORD_W-1:0]  rdata,
   input  logic [NUM_CTR-1:0] inc_evt,
   input  logic [NUM_CTR-1:0] dec_evt,
   input  logic [NUM_CTR-1:0] cnt_live,
   input  logic [NUM_CTR-1:0] roll_p,
   input  logic [NUM_CTR-1:0] badsel_p,
   input  logic [NUM_CTR-1:0] flag_clr
);

   localparam int TOP_ADR = BASE_OFS + STRIDE * (NUM_CTR - 1);

   if (NUM_CTR < 1) begin : g_bad_num
      $error("evt_stat_bank: NUM_CTR must be at least 1");
   end
   if (STRIDE < 1) begin : g_bad_stride
      $error("evt_stat_bank: STRIDE must be positive");
   end
   if (TOP_ADR >= (1 << ADDR_W)) begin : g_bad_span
      $error("evt_stat_bank: address span exceeds ADDR_W");
   end

   logic [NUM_CTR-1:0]       sel_v;
   slot_stat_t [NUM_CTR-1:0] stat_v;
   logic                     rel_req;
   logic                     wdata_unused;

   assign rel_req      = wr_en && wdata[SEM_BIT];
   assign wdata_unused = ^{wdata[WORD_W-1:SEM_BIT+1], wdata[SEM_BIT-1:0]};

   evs_addr_dec #(
      .NUM_CTR  (NUM_CTR),
      .ADDR_W   (ADDR_W),
      .BASE_OFS (BASE_OFS),
      .STRIDE   (STRIDE)
   ) u_dec (
      .addr (addr),
      .sel  (sel_v)
   );

   for (genvar k = 0; k < NUM_CTR; k++) begin : g_slot
      evs_slot #(
         .LIVE_REG (LIVE_REG)
      ) u_slot (
         .clk      (clk),
         .rst_n    (rst_n),
         .inc_evt  (inc_evt[k]),
         .dec_evt  (dec_evt[k]),
         .cnt_live (cnt_live[k]),
         .roll_p   (roll_p[k]),
         .badsel_p (badsel_p[k]),
         .flag_clr (flag_clr[k]),
         .rd_hit   (rd_en && sel_v[k]),
         .rel_hit  (rel_req && sel_v[k]),
         .stat     (stat_v[k])
      );
   end

   evs_rd_mux #(
      .NUM_CTR (NUM_CTR)
   ) u_mux (
      .rd_en  (rd_en),
      .sel    (sel_v),
      .stat_v (stat_v),
      .rdata  (rdata)
   );

endmodule

// File: rtl/evs_chk.sv
module evs_chk
   import evs_pkg::*;
#(
   parameter int NUM_CTR  = 8,
   parameter bit LIVE_REG = 1'b1
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     rd_en,
   input logic                     wr_en,
   input logic [WORD_W-1:0]        wdata,
   input logic [WORD_W-1:0]        rdata,
   input logic [NUM_CTR-1:0]       inc_evt,
   input logic [NUM_CTR-1:0]       dec_evt,
   input logic [NUM_CTR-1:0]       cnt_live,
   input logic [NUM_CTR-1:0]       roll_p,
   input logic [NUM_CTR-1:0]       badsel_p,
   input logic [NUM_CTR-1:0]       flag_clr,
   input logic [NUM_CTR-1:0]       sel,
   input slot_stat_t [NUM_CTR-1:0] stat_v
);

   // R1
   sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(sel));

   // R1
   unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sel == '0) |-> (rdata == '0));

   // R9
   reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rdata[ROLL_BIT-1:0] == '0);

   for (genvar k = 0; k < NUM_CTR; k++) begin : g_chk
      if (LIVE_REG) begin : g_live
         // R2
         dec_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
            rst_n |=> (stat_v[k].dec == $past(dec_evt[k])));
         // R3
         inc_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
            rst_n |=> (stat_v[k].inc == $past(inc_evt[k])));
         // R4
         live_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
            rst_n |=> (stat_v[k].live == $past(cnt_live[k])));
      end

      // R5
      sem_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (rd_en && sel[k] && !(wr_en && wdata[SEM_BIT])) |=> stat_v[k].sem);

      // R6
      sem_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_en && sel[k] && wdata[SEM_BIT]) |=> !stat_v[k].sem);

      // R6
      sem_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !(sel[k] && (rd_en || wr_en)) |=> $stable(stat_v[k].sem));

      // R7
      bad_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
         badsel_p[k] |=> stat_v[k].bad);

      // R7
      bad_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (flag_clr[k] && !badsel_p[k]) |=> !stat_v[k].bad);

      // R8
      roll_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
         roll_p[k] |=> stat_v[k].roll);

      // R8
      roll_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (!roll_p[k] && !flag_clr[k]) |=> $stable(stat_v[k].roll));
   end

endmodule

bind evt_stat_bank evs_chk #(
   .NUM_CTR  (NUM_CTR),
   .LIVE_REG (LIVE_REG)
) u_evs_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .rd_en    (rd_en),
   .wr_en    (wr_en),
   .wdata    (wdata),
   .rdata    (rdata),
   .inc_evt  (inc_evt),
   .dec_evt  (dec_evt),
   .cnt_live (cnt_live),
   .roll_p   (roll_p),
   .badsel_p (badsel_p),
   .flag_clr (flag_clr),
   .sel      (sel_v),
   .stat_v   (stat_v)
);

// File: tb/test_evt_stat_bank.sv
module test_evt_stat_bank;

   localparam int CLK_P = 10;
   localparam int N     = 8;
   localparam logic [31:0] SEM = 32'h1000_0000;

   // each entry: {inc[7:0], dec[7:0], live[7:0]}
   localparam logic [23:0] VEC [5] = '{
      {8'hA5, 8'h3C, 8'hFF},
      {8'h5A, 8'hC3, 8'h00},
      {8'hFF, 8'h00, 8'h0F},
      {8'h00, 8'hFF, 8'hF0},
      {8'h81, 8'h42, 8'h24}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rd_en = 1'b0;
   logic        wr_en = 1'b0;
   logic [7:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic [N-1:0] inc_evt = '0, dec_evt = '0, cnt_live = '0;
   logic [N-1:0] roll_p = '0, badsel_p = '0, flag_clr = '0;

   int checks = 0;
   int fails  = 0;
   bit sem_m [N];

   always #(CLK_P/2) clk = ~clk;

   evt_stat_bank i_evt_stat_bank (
      .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en),
      .addr(addr), .wdata(wdata), .rdata(rdata),
      .inc_evt(inc_evt), .dec_evt(dec_evt), .cnt_live(cnt_live),
      .roll_p(roll_p), .badsel_p(badsel_p), .flag_clr(flag_clr)
   );

   function automatic logic [7:0] slot_adr(int k);
      return 8'(8 + 16 * k);
   endfunction

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
      end
   endtask

   task automatic rd(logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      rd_en = 1'b1; addr = a;
      #1 d = rdata;
      @(posedge clk); #1;
      rd_en = 1'b0;
   endtask

   task automatic wr(logic [7:0] a, logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = a; wdata = d;
      @(posedge clk); #1;
      wr_en = 1'b0; wdata = '0;
   endtask

   task automatic rdwr(logic [7:0] a, logic [31:0] d, output logic [31:0] q);
      @(negedge clk);
      rd_en = 1'b1; wr_en = 1'b1; addr = a; wdata = d;
      #1 q = rdata;
      @(posedge clk); #1;
      rd_en = 1'b0; wr_en = 1'b0; wdata = '0;
   endtask

   task automatic pulse(ref logic [N-1:0] v, input logic [N-1:0] m);
      @(negedge clk);
      v = m;
      @(posedge clk); #1;
      v = '0;
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
   endtask

   initial begin
      #(CLK_P * 50000);
      checks++; fails++;
      $display("FAIL R10 watchdog actual=running expected=finished");
      summary();
      $finish;
   end

   initial begin
      logic [31:0] d;
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;

      // R10: reset state, first read of each semaphore is 0 (R5)
      for (int k = 0; k < N; k++) begin
         rd(slot_adr(k), d);
         chk("R10 reset word", d, 32'h0);
         sem_m[k] = 1'b1;
      end

      // R2 R3 R4 R5: table of live patterns
      for (int v = 0; v < 5; v++) begin
         @(negedge clk);
         inc_evt = VEC[v][23:16]; dec_evt = VEC[v][15:8]; cnt_live = VEC[v][7:0];
         @(posedge clk); #1;
         for (int k = 0; k < N; k++) begin
            rd(slot_adr(k), d);
            chk("R2 R3 R4 R5 live word", d,
                {VEC[v][8+k], VEC[v][16+k], VEC[v][k], sem_m[k], 28'h0});
         end
      end
      @(negedge clk);
      inc_evt = '0; dec_evt = '0; cnt_live = '0;

      // R6: write 0 no effect, write 1 releases, next read takes again
      wr(slot_adr(2), 32'hEFFF_FFFF);
      rd(slot_adr(2), d);
      chk("R6 write zero keeps", d, SEM);
      wr(slot_adr(2), SEM);
      rd(slot_adr(2), d);
      chk("R6 release", d, 32'h0);
      rd(slot_adr(2), d);
      chk("R5 retake", d, SEM);

      // R6: read and release in same cycle
      rdwr(slot_adr(3), SEM, d);
      chk("R6 concurrent read value", d, SEM);
      rd(slot_adr(3), d);
      chk("R6 concurrent release wins", d, 32'h0);

      // R1: map and unmapped accesses
      wr(8'h10, SEM);
      wr(8'h09, SEM);
      rd(slot_adr(0), d);
      chk("R1 unmapped write ignored", d, SEM);
      rd(slot_adr(1), d);
      chk("R1 neighbour untouched", d, SEM);
      rd(8'h00, d);
      chk("R1 addr 00 zero", d, 32'h0);
      rd(8'h88, d);
      chk("R1 addr 88 zero", d, 32'h0);
      rd(8'h0C, d);
      chk("R1 addr 0C zero", d, 32'h0);

      // R7: bad selection flag
      pulse(badsel_p, 8'h20);
      rd(slot_adr(5), d);
      chk("R7 bad set", d, 32'h1800_0000);
      rd(slot_adr(5), d);
      chk("R7 bad sticky", d, 32'h1800_0000);
      rd(slot_adr(4), d);
      chk("R7 other slot clean", d, SEM);
      pulse(flag_clr, 8'h20);
      rd(slot_adr(5), d);
      chk("R7 bad cleared", d, SEM);
      @(negedge clk);
      badsel_p = 8'h20; flag_clr = 8'h20;
      @(posedge clk); #1;
      badsel_p = '0; flag_clr = '0;
      rd(slot_adr(5), d);
      chk("R7 set beats clear", d, 32'h1800_0000);

      // R8: wrap flag
      pulse(roll_p, 8'h80);
      rd(slot_adr(7), d);
      chk("R8 roll set", d, 32'h1400_0000);
      @(negedge clk);
      roll_p = 8'h80; flag_clr = 8'h80;
      @(posedge clk); #1;
      roll_p = '0; flag_clr = '0;
      rd(slot_adr(7), d);
      chk("R8 set beats clear", d, 32'h1400_0000);
      pulse(flag_clr, 8'h80);
      rd(slot_adr(7), d);
      chk("R8 roll cleared", d, SEM);
      rd(slot_adr(5), d);
      chk("R7 flag kept across other clear", d, 32'h1800_0000);

      // R9: everything high, reserved field still zero
      @(negedge clk);
      inc_evt = '1; dec_evt = '1; cnt_live = '1; roll_p = '1; badsel_p = '1;
      @(posedge clk); #1;
      roll_p = '0; badsel_p = '0;
      rd(slot_adr(1), d);
      chk("R9 full word", d, 32'hFC00_0000);
      rd(slot_adr(6), d);
      chk("R9 reserved zero", d & 32'h03FF_FFFF, 32'h0);

      summary();
      $finish;
   end

endmodule